// File: doc/BRIEF.md
# Coin-Operated Countdown Meter Controller

The block models the timing core of a parking meter. Six single-cycle pulse inputs change the time left on the meter. Four of them add 60, 120, 180 or 300 seconds. Two of them overwrite the time with a preset of 16 or 150 seconds. From a 100 Hz clock the block counts the time left down by one second every 100 cycles. Any sum above 9999 is held at 9999.

The time left is kept as four cascaded BCD digits and is driven out as four 4-bit digit outputs. A single display-enable output creates the blink patterns for the later display stage:

- At zero, which covers both the idle state after reset and the expired state, the enable gives a steady flash of 0000 at 1 s period and 50% duty.
- Below 180 seconds, the enable shows even counts and blanks odd ones, which gives a 2 s blink.
- At 180 seconds or more, the enable stays on.

The seven-segment decoding and the digit multiplexing that use these outputs sit outside this block.

Top module: `coin_meter`

## Requirements
- R1: After the active-low asynchronous reset `rst_ni` is released, the time left is 0000 and `disp_en_o` is high for the first 50 clock cycles.
- R2: A pulse on `add_60_i`, `add_120_i`, `add_180_i` or `add_300_i` raises the time by 60, 120, 180 or 300 seconds. The new value appears on the digit outputs on the clock edge that samples the pulse. BCD carries ripple across the digits.
- R3: A pulse on `set_16_i` loads exactly 0016. A pulse on `set_150_i` loads exactly 0150. Countdown continues from the loaded value.
- R4: The time left drops by exactly one every 100 clock cycles. Any add or preset pulse restarts this period, so the first decrement after a pulse lands on the 100th edge after the pulse edge. Without a pulse, the time never changes by more than one per cycle.
- R5: An add that would take the total above 9999 leaves the time at 9999, and countdown resumes from 9999.
- R6: Once the time is 0000, it stays 0000 until an add or preset pulse arrives. It never wraps.
- R7: While the time is 0000, `disp_en_o` follows a free-running counter: 50 cycles high, then 50 cycles low.
- R8: While the time is between 0001 and 0179, `disp_en_o` is high when the count is even and low when it is odd. The parity is bit 0 of the ones digit.
- R9: While the time is 0180 or more, `disp_en_o` stays high.
- R10: Each digit output is a BCD value from 0 to 9. `digit1_o` is the thousands digit, `digit2_o` the hundreds, `digit3_o` the tens and `digit4_o` the ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 100 Hz system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| add_60_i | input | 1 | Single-cycle pulse that adds 60 s |
| add_120_i | input | 1 | Single-cycle pulse that adds 120 s |
| add_180_i | input | 1 | Single-cycle pulse that adds 180 s |
| add_300_i | input | 1 | Single-cycle pulse that adds 300 s |
| set_16_i | input | 1 | Single-cycle pulse that loads 16 s |
| set_150_i | input | 1 | Single-cycle pulse that loads 150 s |
| digit1_o | output | 4 | Thousands digit (BCD) |
| digit2_o | output | 4 | Hundreds digit (BCD) |
| digit3_o | output | 4 | Tens digit (BCD) |
| digit4_o | output | 4 | Ones digit (BCD) |
| disp_en_o | output | 1 | Display enable carrying the blink pattern |

## Verification
The state that matters lives in three places: the digit counters, the one-second prescaler and the half-second flash counter. A wrong digit carry or borrow shows on the digit outputs at the edge that samples the pulse, or at the first decrement across a digit boundary such as 0300 to 0299. A prescaler that does not restart, or that counts the wrong period, moves that decrement off the 100th edge, so the bench samples both one cycle before and one cycle after that edge. A fault in the blink selection shows on `disp_en_o` within one second of crossing 180, of reaching zero, or of leaving reset.

// File: rtl/meter_pkg.sv
package meter_pkg;
  localparam int NUM_DIGITS = 4;
  localparam int TIME_W     = 4 * NUM_DIGITS;

  typedef logic [TIME_W-1:0] time_bcd_t;

  localparam time_bcd_t AMT_60   = 16'h0060;
  localparam time_bcd_t AMT_120  = 16'h0120;
  localparam time_bcd_t AMT_180  = 16'h0180;
  localparam time_bcd_t AMT_300  = 16'h0300;
  localparam time_bcd_t PRE_16   = 16'h0016;
  localparam time_bcd_t PRE_150  = 16'h0150;
  localparam time_bcd_t LOW_MARK = 16'h0180;
endpackage

// File: rtl/meter_prescaler.sv
module meter_prescaler #(
  parameter int TICKS = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic tick_o
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(TICKS - 1)) && !restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (restart_i)                   cnt_q <= '0;
    else if (cnt_q == CW'(TICKS - 1))     cnt_q <= '0;
    else                                  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/meter_time_bcd.sv
module meter_time_bcd #(
  parameter int NDIG = 4,
  localparam int W   = 4 * NDIG
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         add_i,
  input  logic [W-1:0] add_val_i,
  input  logic         dec_i,
  output logic [W-1:0] time_o,
  output logic         zero_o
);
  logic [W-1:0] time_q;
  logic [W-1:0] sum_v;
  logic [W-1:0] dec_v;
  logic [NDIG:0] carry;
  logic [NDIG:0] borrow;

  assign carry[0]  = 1'b0;
  assign borrow[0] = 1'b1;

  for (genvar g = 0; g < NDIG; g++) begin : g_digit
    logic [4:0] raw;
    logic [4:0] adj;
    assign raw = {1'b0, time_q[4*g +: 4]} + {1'b0, add_val_i[4*g +: 4]} + {4'd0, carry[g]};
    assign adj = raw - 5'd10;
    assign carry[g+1] = (raw > 5'd9);
    assign sum_v[4*g +: 4] = carry[g+1] ? adj[3:0] : raw[3:0];

    assign borrow[g+1] = borrow[g] && (time_q[4*g +: 4] == 4'd0);
    assign dec_v[4*g +: 4] = !borrow[g] ? time_q[4*g +: 4] :
                             (time_q[4*g +: 4] == 4'd0) ? 4'd9 :
                             time_q[4*g +: 4] - 4'd1;
  end

  // saturation decided before the digits are written back
  logic         sat;
  assign sat    = carry[NDIG];
  assign zero_o = (time_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               time_q <= '0;
    else if (load_i)           time_q <= load_val_i;
    else if (add_i)            time_q <= sat ? {NDIG{4'd9}} : sum_v;
    else if (dec_i && !zero_o) time_q <= dec_v;
  end

  assign time_o = time_q;
endmodule

// File: rtl/meter_display_en.sv
module meter_display_en #(
  parameter int NDIG       = 4,
  parameter int HALF_TICKS = 50,
  localparam int W         = 4 * NDIG
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] time_i,
  input  logic [W-1:0] low_mark_i,
  output logic         en_o
);
  localparam int CW = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;

  logic [CW-1:0] half_q;
  logic          phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q  <= '0;
      phase_q <= 1'b1;
    end else if (half_q == CW'(HALF_TICKS - 1)) begin
      half_q  <= '0;
      phase_q <= !phase_q;
    end else begin
      half_q  <= half_q + 1'b1;
    end
  end

  // BCD compares like binary, so a plain magnitude compare is valid
  always_comb begin
    if (time_i == '0)             en_o = phase_q;
    else if (time_i < low_mark_i) en_o = !time_i[0];
    else                          en_o = 1'b1;
  end
endmodule

// File: rtl/coin_meter.sv
module coin_meter
  import meter_pkg::*;
#(
  parameter int SEC_TICKS  = 100,
  parameter int HALF_TICKS = 50
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       add_60_i,
  input  logic       add_120_i,
  input  logic       add_180_i,
  input  logic       add_300_i,
  input  logic       set_16_i,
  input  logic       set_150_i,
  output logic [3:0] digit1_o,
  output logic [3:0] digit2_o,
  output logic [3:0] digit3_o,
  output logic [3:0] digit4_o,
  output logic       disp_en_o
);
  logic      add_any, load_any, tick, zero;
  time_bcd_t add_val, load_val, time_v;

  assign add_any  = add_60_i | add_120_i | add_180_i | add_300_i;
  assign load_any = set_16_i | set_150_i;

  always_comb begin
    add_val = '0;
    if (add_60_i)       add_val = AMT_60;
    else if (add_120_i) add_val = AMT_120;
    else if (add_180_i) add_val = AMT_180;
    else if (add_300_i) add_val = AMT_300;
    load_val = set_16_i ? PRE_16 : PRE_150;
  end

  meter_prescaler #(.TICKS(SEC_TICKS)) u_presc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(add_any | load_any),
    .tick_o   (tick)
  );

  meter_time_bcd #(.NDIG(NUM_DIGITS)) u_time (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_any),
    .load_val_i(load_val),
    .add_i     (add_any),
    .add_val_i (add_val),
    .dec_i     (tick),
    .time_o    (time_v),
    .zero_o    (zero)
  );

  meter_display_en #(.NDIG(NUM_DIGITS), .HALF_TICKS(HALF_TICKS)) u_disp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .time_i    (time_v),
    .low_mark_i(LOW_MARK),
    .en_o      (disp_en_o)
  );

  assign {digit1_o, digit2_o, digit3_o, digit4_o} = time_v;
endmodule

// File: rtl/coin_meter_chk.sv
module coin_meter_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        add60_i,
  input logic        add_any_i,
  input logic        pulse_any_i,
  input logic        set16_i,
  input logic [15:0] time_i,
  input logic        en_i
);
  function automatic int to_bin(logic [15:0] v);
    return int'(v[15:12]) * 1000 + int'(v[11:8]) * 100 + int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  int bin;
  assign bin = to_bin(time_i);

  AST_DIGIT_BCD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_i[15:12] <= 4'd9 && time_i[11:8] <= 4'd9 && time_i[7:4] <= 4'd9 && time_i[3:0] <= 4'd9); // R10
  AST_ADD_SIXTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    add60_i && bin <= 9939 |=> bin == $past(bin) + 60); // R2
  AST_PRESET_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set16_i |=> time_i == 16'h0016); // R3
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse_any_i |=> (bin == $past(bin)) || (bin + 1 == $past(bin))); // R4
  AST_SAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    add_any_i && time_i == 16'h9999 |=> time_i == 16'h9999); // R5
  AST_ZERO_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_i == 16'h0000 && !pulse_any_i |=> time_i == 16'h0000); // R6
  AST_LOW_PARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_i != 16'h0000 && time_i < 16'h0180 |-> en_i == !time_i[0]); // R8
  AST_HIGH_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_i >= 16'h0180 |-> en_i); // R9
endmodule

bind coin_meter coin_meter_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .add60_i    (add_60_i),
  .add_any_i  (add_60_i | add_120_i | add_180_i | add_300_i),
  .pulse_any_i(add_60_i | add_120_i | add_180_i | add_300_i | set_16_i | set_150_i),
  .set16_i    (set_16_i),
  .time_i     ({digit1_o, digit2_o, digit3_o, digit4_o}),
  .en_i       (disp_en_o)
);

// File: tb/coin_meter_test.sv
`timescale 1ns/1ps
module coin_meter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a60 = 0, a120 = 0, a180 = 0, a300 = 0, s16 = 0, s150 = 0;
  logic [3:0] d1, d2, d3, d4;
  logic en;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  coin_meter uut (
    .clk_i(clk), .rst_ni(rst_n),
    .add_60_i(a60), .add_120_i(a120), .add_180_i(a180), .add_300_i(a300),
    .set_16_i(s16), .set_150_i(s150),
    .digit1_o(d1), .digit2_o(d2), .digit3_o(d3), .digit4_o(d4),
    .disp_en_o(en)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_time(input string tag, input logic [15:0] exp_v);
    n_chk++;
    if ({d1, d2, d3, d4} !== exp_v) begin
      n_bad++;
      $display("FAIL %s time actual=%h expected=%h", tag, {d1, d2, d3, d4}, exp_v);
    end
  endtask

  task automatic chk_en(input string tag, input logic exp_v);
    n_chk++;
    if (en !== exp_v) begin
      n_bad++;
      $display("FAIL %s disp_en actual=%b expected=%b", tag, en, exp_v);
    end
  endtask

  // sel: 0..3 adds 60/120/180/300, 4 loads 16, 5 loads 150
  task automatic pulse(input int sel);
    @(negedge clk);
    case (sel)
      0: a60 = 1; 1: a120 = 1; 2: a180 = 1; 3: a300 = 1; 4: s16 = 1; default: s150 = 1;
    endcase
    @(negedge clk);
    {a60, a120, a180, a300, s16, s150} = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_flash();
    do_reset();
    wait_n(10);
    chk_time("R1 reset", 16'h0000);
    chk_en("R1 first half", 1'b1);
    wait_n(50);
    chk_en("R7 off half", 1'b0);
    wait_n(50);
    chk_en("R7 on again", 1'b1);
  endtask

  task automatic t_add_decrement();
    do_reset();
    pulse(3);
    chk_time("R2 add 300", 16'h0300);
    wait_n(99);
    chk_time("R4 before first edge", 16'h0300);
    wait_n(1);
    chk_time("R4 first decrement", 16'h0299);
    wait_n(50);
    pulse(2);
    chk_time("R2 add 180 carry", 16'h0479);
    pulse(1);
    chk_time("R2 add 120", 16'h0599);
    pulse(0);
    chk_time("R2 add 60", 16'h0659);
    wait_n(99);
    chk_time("R4 restart hold", 16'h0659);
    wait_n(1);
    chk_time("R4 restart step", 16'h0658);
  endtask

  task automatic t_preset_expire();
    do_reset();
    pulse(4);
    chk_time("R3 load 16", 16'h0016);
    chk_en("R8 even 16", 1'b1);
    wait_n(150);
    chk_time("R4 15", 16'h0015);
    chk_en("R8 odd 15", 1'b0);
    wait_n(1500);
    chk_time("R6 reached zero", 16'h0000);
    wait_n(250);
    chk_time("R6 no wrap", 16'h0000);
  endtask

  task automatic t_low_blink();
    do_reset();
    pulse(5);
    chk_time("R3 load 150", 16'h0150);
    wait_n(50);
    pulse(0);
    chk_time("R2 150+60", 16'h0210);
    wait_n(2950);
    chk_time("R9 181", 16'h0181);
    chk_en("R9 odd above mark", 1'b1);
    wait_n(100);
    chk_time("R9 180", 16'h0180);
    chk_en("R9 at mark", 1'b1);
    wait_n(100);
    chk_en("R8 179 blank", 1'b0);
    wait_n(100);
    chk_time("R8 178", 16'h0178);
    chk_en("R8 178 shown", 1'b1);
  endtask

  task automatic t_saturate();
    do_reset();
    for (int i = 0; i < 33; i++) pulse(3);
    chk_time("R2 33x300", 16'h9900);
    pulse(1);
    chk_time("R5 clamp", 16'h9999);
    pulse(0);
    chk_time("R5 hold at max", 16'h9999);
    chk_en("R9 max on", 1'b1);
    wait_n(100);
    chk_time("R5 counts down", 16'h9998);
  endtask

  initial begin
    #800000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset_flash();
    t_add_decrement();
    t_preset_expire();
    t_low_blink();
    t_saturate();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule